// File: doc/BRIEF.md
# Isochronous Bus Cycle Timer with Cycle-Start Mastering

This block keeps the bus cycle timer of a serial-bus node. It has three fields. The first is a cycle offset that counts timer clocks (3072 per 125 µs cycle at 24.576 MHz). The second is a cycle number that counts completed cycles up to 8000, one second. The third is a seconds count that advances each time the cycle number wraps. The cycle boundary, called a rollover, comes from one of two places. With the internal source, it comes from the offset count limit. With the external source, it comes from the edges of an asynchronous cycle-input pin.

A node that is bus root and has mastering enabled asks its transmitter for a cycle-start packet at every rollover. It does this through a one-clock request strobe. A node that is not root follows the bus instead: each received cycle-start value overwrites the whole timer. Packet formatting and transmission belong to other blocks.

Top module: `cyc_timer_master`

## Requirements
- R1: After reset the offset, cycle and seconds outputs are 0 and the request strobe is low.
- R2: With the internal source (`src_ext` = 0) and `tmr_en` = 1, the offset steps by one per clock from 0 up to OFF_LIMIT-1, then returns to 0 on the next clock (a rollover).
- R3: While `tmr_en` = 0, all three timer fields hold their values and no rollover happens. External pulses that arrive in this state are lost.
- R4: Each rollover adds one to the cycle number. When the cycle number is at CYC_LIMIT-1, a rollover returns it to 0 and adds one to the seconds count, which wraps modulo 2^SEC_W.
- R5: With the external source (`src_ext` = 1) and `tmr_en` = 1, the offset saturates at OFF_LIMIT-1 instead of rolling over. Suppose `ext_cycle_in` is sampled high at rising edge k after being sampled low at edge k-1. Then one rollover takes effect at edge k+2. Holding the pin high causes no further rollover. With the internal source, the pin has no effect.
- R6: When `is_root` = 1 and `master_en` = 1 at a rollover edge, `cyc_start_req` is high for exactly the clock in which the offset has just returned to 0 through that rollover.
- R7: When `is_root` = 0 or `master_en` = 0 at a rollover edge, `cyc_start_req` stays low.
- R8: When `is_root` = 0 and `rx_valid` = 1 at a rising edge, the seconds, cycle and offset outputs equal `rx_seconds`, `rx_cycle` and `rx_offset` after that edge. This holds whatever `tmr_en`, `master_en` and `src_ext` are, and it issues no request. Received values must lie within the field limits.
- R9: When `is_root` = 1, `rx_valid` is ignored and the timer advances as if it were low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock (24.576 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_en | input | 1 | Timer count enable |
| src_ext | input | 1 | Rollover source: 0 internal limit, 1 external pin |
| master_en | input | 1 | Cycle-start mastering enable |
| is_root | input | 1 | Node is currently bus root |
| ext_cycle_in | input | 1 | Asynchronous external cycle pulse |
| rx_valid | input | 1 | Received cycle-start value strobe |
| rx_seconds | input | SEC_W | Received seconds field |
| rx_cycle | input | CYC_W | Received cycle field |
| rx_offset | input | OFF_W | Received offset field |
| sec_o | output | SEC_W | Seconds count |
| cyc_o | output | CYC_W | Cycle number |
| off_o | output | OFF_W | Cycle offset |
| cyc_start_req | output | 1 | One-clock cycle-start request |

## Verification
The bench builds the timer with OFF_LIMIT = 8, CYC_LIMIT = 5 and SEC_W = 3. This shrinks a full second to 40 clocks and the whole seconds range to 320 clocks. Offset saturation, cycle wrap and seconds wrap therefore recur many times in a short run. With the narrow fields, random received values also land on each field's last value often. The defaults (3072, 8000, 7 bits) change only the limits, not the paths the bench covers.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;

    typedef enum logic {
        ROLL_INTERNAL = 1'b0,
        ROLL_EXTERNAL = 1'b1
    } roll_src_e;

endpackage

// File: rtl/cyc_edge_sync.sv
module cyc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        st_d.last = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_pulse = st_q.chain[STAGES-1] & ~st_q.last;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse); // R5

endmodule

// File: rtl/cyc_wrap_counter.sv
module cyc_wrap_counter #(
    parameter int WIDTH = 13,
    parameter int LIMIT = 8000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             step,
    output logic [WIDTH-1:0] value,
    output logic             wrap
);
    localparam logic [WIDTH-1:0] LAST = WIDTH'(LIMIT - 1);

    logic [WIDTH-1:0] cnt_d, cnt_q;
    logic             at_last;

    always_comb begin
        at_last = (cnt_q == LAST);
        cnt_d   = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (step) begin
            cnt_d = at_last ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign value = cnt_q;
    assign wrap  = step & ~load & at_last;

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/cyc_timer_master.sv
module cyc_timer_master
    import cyc_timer_pkg::*;
#(
    parameter int OFF_W       = 12,
    parameter int OFF_LIMIT   = 3072,
    parameter int CYC_W       = 13,
    parameter int CYC_LIMIT   = 8000,
    parameter int SEC_W       = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_en,
    input  logic             src_ext,
    input  logic             master_en,
    input  logic             is_root,
    input  logic             ext_cycle_in,
    input  logic             rx_valid,
    input  logic [SEC_W-1:0] rx_seconds,
    input  logic [CYC_W-1:0] rx_cycle,
    input  logic [OFF_W-1:0] rx_offset,
    output logic [SEC_W-1:0] sec_o,
    output logic [CYC_W-1:0] cyc_o,
    output logic [OFF_W-1:0] off_o,
    output logic             cyc_start_req
);
    localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(OFF_LIMIT - 1);
    localparam int               SEC_LIMIT = 1 << SEC_W;

    typedef struct packed {
        logic [OFF_W-1:0] off;
        logic             req;
    } tmr_st_t;

    tmr_st_t   st_d, st_q;
    roll_src_e src;
    logic      ext_rise;
    logic      load_rx;
    logic      roll;
    logic      cyc_wrap;
    logic      sec_wrap;

    cyc_edge_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_in  (ext_cycle_in),
        .rise_pulse(ext_rise)
    );

    always_comb begin
        src     = roll_src_e'(src_ext);
        load_rx = rx_valid & ~is_root;
        roll    = 1'b0;
        if (tmr_en && !load_rx) begin
            roll = (src == ROLL_EXTERNAL) ? ext_rise : (st_q.off == OFF_LAST);
        end

        st_d     = st_q;
        st_d.req = roll & is_root & master_en;
        if (load_rx) begin
            st_d.off = rx_offset;
        end else if (roll) begin
            st_d.off = '0;
        end else if (tmr_en && st_q.off != OFF_LAST) begin
            st_d.off = st_q.off + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    cyc_wrap_counter #(
        .WIDTH(CYC_W),
        .LIMIT(CYC_LIMIT)
    ) u_cycle (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_rx),
        .load_val(rx_cycle),
        .step    (roll),
        .value   (cyc_o),
        .wrap    (cyc_wrap)
    );

    cyc_wrap_counter #(
        .WIDTH(SEC_W),
        .LIMIT(SEC_LIMIT)
    ) u_seconds (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_rx),
        .load_val(rx_seconds),
        .step    (cyc_wrap),
        .value   (sec_o),
        .wrap    (sec_wrap)
    );

    assign off_o         = st_q.off;
    assign cyc_start_req = st_q.req;

    AST_OFF_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        off_o <= OFF_LAST); // R2
    AST_CYC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_o <= CYC_W'(CYC_LIMIT - 1)); // R4
    AST_REQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start_req |-> (off_o == '0)); // R6
    AST_REQ_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start_req |=> !cyc_start_req); // R6
    AST_NO_REQ_UNMASTERED: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_root || !master_en) |=> !cyc_start_req); // R7
    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_en && !load_rx) |=> ($stable(off_o) && $stable(cyc_o) && $stable(sec_o))); // R3
    AST_RX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !is_root) |=> (off_o == $past(rx_offset) && cyc_o == $past(rx_cycle)
                                    && sec_o == $past(rx_seconds) && !cyc_start_req)); // R8
    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        sec_wrap |=> (sec_o == '0)); // R4

endmodule

// File: tb/cyc_timer_master_test.sv
module cyc_timer_master_test;
    localparam int CLK_PERIOD = 10;
    localparam int OFF_W = 4, OFF_LIMIT = 8, CYC_W = 3, CYC_LIMIT = 5, SEC_W = 3;
    localparam int WATCHDOG = 200000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic tmr_en = 0, src_ext = 0, master_en = 0, is_root = 0, ext_cycle_in = 0, rx_valid = 0;
    logic [SEC_W-1:0] rx_seconds = '0;
    logic [CYC_W-1:0] rx_cycle = '0;
    logic [OFF_W-1:0] rx_offset = '0;
    logic [SEC_W-1:0] sec_o;
    logic [CYC_W-1:0] cyc_o;
    logic [OFF_W-1:0] off_o;
    logic cyc_start_req;

    int n_tests = 0, n_fail = 0, n_cycles = 0;
    int m_off = 0, m_cyc = 0, m_sec = 0, m_req = 0;
    int h1 = 0, h2 = 0, h3 = 0;
    string m_tag = "R1", q_tag = "R7";

    always #(CLK_PERIOD/2) clk = ~clk;

    cyc_timer_master #(
        .OFF_W(OFF_W), .OFF_LIMIT(OFF_LIMIT), .CYC_W(CYC_W),
        .CYC_LIMIT(CYC_LIMIT), .SEC_W(SEC_W), .SYNC_STAGES(2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .src_ext(src_ext),
        .master_en(master_en), .is_root(is_root), .ext_cycle_in(ext_cycle_in),
        .rx_valid(rx_valid), .rx_seconds(rx_seconds), .rx_cycle(rx_cycle),
        .rx_offset(rx_offset), .sec_o(sec_o), .cyc_o(cyc_o), .off_o(off_o),
        .cyc_start_req(cyc_start_req)
    );

    function automatic int next_cyc(int c);
        return (c == CYC_LIMIT - 1) ? 0 : c + 1;
    endfunction

    // Reference model, evaluated from the requirements at each rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_off = 0; m_cyc = 0; m_sec = 0; m_req = 0;
            h1 = 0; h2 = 0; h3 = 0;
            m_tag = "R1"; q_tag = "R7";
        end else begin
            int pulse, roll, ld;
            pulse = (h2 == 1 && h3 == 0) ? 1 : 0;   // R5: edge k sampled, acts at k+2
            h3 = h2; h2 = h1; h1 = int'(ext_cycle_in);
            ld = (rx_valid && !is_root) ? 1 : 0;
            roll = 0;
            if (tmr_en && !ld)
                roll = src_ext ? pulse : int'(m_off == OFF_LIMIT - 1);
            m_req = (roll && is_root && master_en) ? 1 : 0;
            q_tag = m_req ? "R6" : "R7";
            if (ld) begin
                m_off = rx_offset; m_cyc = rx_cycle; m_sec = rx_seconds; m_tag = "R8";
            end else if (roll) begin
                m_off = 0;
                if (m_cyc == CYC_LIMIT - 1) m_sec = (m_sec + 1) % (1 << SEC_W);
                m_cyc = next_cyc(m_cyc);
                m_tag = src_ext ? "R5" : (m_cyc == 0 ? "R4" : "R2");
            end else if (tmr_en) begin
                if (m_off != OFF_LIMIT - 1) m_off = m_off + 1;
                m_tag = src_ext ? "R5" : "R2";
            end else begin
                m_tag = "R3";
            end
            if (is_root && rx_valid) m_tag = "R9";
        end
    end

    task automatic check(string tag, int act, int exp, string what);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", tag, what, act, exp, n_cycles);
        end
    endtask

    task automatic compare_all();
        check(m_tag, int'(off_o), m_off, "offset");
        check(m_tag, int'(cyc_o), m_cyc, "cycle");
        check(m_tag, int'(sec_o), m_sec, "seconds");
        check(q_tag, int'(cyc_start_req), m_req, "request");
    endtask

    // Drive after the falling edge, compare before driving
    task automatic step(input logic en, input logic ext, input logic mst, input logic root,
                        input logic pin, input logic rv);
        @(negedge clk);
        compare_all();
        tmr_en = en; src_ext = ext; master_en = mst; is_root = root;
        ext_cycle_in = pin; rx_valid = rv;
        rx_offset  = OFF_W'($urandom % OFF_LIMIT);
        rx_cycle   = CYC_W'($urandom % CYC_LIMIT);
        rx_seconds = SEC_W'($urandom);
        n_cycles++;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20231));
        #(CLK_PERIOD * 3);
        @(negedge clk);
        check("R1", int'(off_o), 0, "reset offset");
        check("R1", int'(cyc_o), 0, "reset cycle");
        check("R1", int'(sec_o), 0, "reset seconds");
        check("R1", int'(cyc_start_req), 0, "reset request");
        rst_n = 1'b1;

        // Directed: internal count as mastering root, through second wraps (R2, R4, R6)
        for (int i = 0; i < 700; i++) step(1, 0, 1, 1, 0, 0);
        // Directed: load last values then hold disabled (R8, R3)
        @(negedge clk);
        compare_all();
        is_root = 0; rx_valid = 1; tmr_en = 0;
        rx_offset = OFF_W'(OFF_LIMIT - 1); rx_cycle = CYC_W'(CYC_LIMIT - 1); rx_seconds = '1;
        for (int i = 0; i < 6; i++) step(0, 0, 1, 0, 1, 0);
        for (int i = 0; i < 12; i++) step(1, 0, 0, 0, 0, 0);
        // Random enable toggling, internal source (R3, R7, R5 pin ignored)
        for (int i = 0; i < 600; i++)
            step(logic'($urandom % 4 != 0), 0, logic'($urandom % 2), 1, logic'($urandom % 2), 0);
        // External source: saturation and pulse rollovers (R5, R6)
        for (int i = 0; i < 800; i++)
            step(logic'($urandom % 8 != 0), 1, 1, 1, logic'(($urandom % 16) < 3), 0);
        // Pin held high: one rollover only (R5)
        for (int i = 0; i < 30; i++) step(1, 1, 1, 1, 1, 0);
        // Non-root follows received values, never requests (R7, R8)
        for (int i = 0; i < 600; i++)
            step(logic'($urandom % 2), logic'($urandom % 2), logic'($urandom % 2), 0,
                 logic'($urandom % 2), logic'($urandom % 8 == 0));
        // Root ignores received values (R9)
        for (int i = 0; i < 600; i++)
            step(1, 0, 1, 1, 0, logic'($urandom % 3 == 0));
        @(negedge clk);
        compare_all();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule